// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a register-driven master engine for a two-wire serial bus. Software sets a level-sensitive run bit. The core then raises a START condition and shifts out a calling address taken from one of two address registers. After that it moves data one byte at a time through a single shared data buffer. Software paces each byte with two ready bits. One bit tells the core that the buffer holds a byte to send. The other tells the core that a received byte is waiting to be read. Clearing the run bit ends the transfer with a STOP condition once the byte in progress is complete.

Both bus lines are open-drain. An output-enable of 1 pulls the line low, and 0 releases it. Each SCL period is split into four equal quarter phases, and a 3-bit rate code sets the quarter length. Bit 0 of the selected address register is sent as the read/write bit. It decides whether the core drives data bytes or clocks them in after the address.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, tx_rdy, rx_rdy, tx_flag, rx_flag and ack_seen are all 0. addr_a_q is A0h and addr_b_q is 00h. Both scl_oe and sda_oe are 0, so both lines are released.
- R2: While go is 1 in idle, the core pulls SDA low while SCL is high (START). It then sends 8 bits MSB first from addr_a_q when addr_sel is 0, or from addr_b_q when addr_sel is 1. Bit 0 of that register is the read/write bit.
- R3: Within a transfer, SDA changes only while SCL is low. The only SDA edges seen while SCL is high are the single START and the single STOP.
- R4: When the read/write bit is 0, the core holds SCL low after each byte until tx_rdy is 1. It then copies the buffer into the shifter, sets tx_flag, and sends the byte MSB first.
- R5: tx_rdy stays 1 through the eight data bits of a sent byte. The core clears it after the ninth clock of that byte.
- R6: After each byte the core sends, including the address, ack_seen takes the SDA level sampled in the ninth clock: 0 means acknowledged and 1 means not acknowledged.
- R7: When the read/write bit is 1, the core starts clocking in a byte only while rx_rdy is 0. While rx_rdy is 1, SCL stays low and no clock pulses are produced.
- R8: At the end of the ninth clock of a received byte, the core writes the byte into the buffer and sets rx_rdy and rx_flag. The buffer keeps that byte while rx_rdy is 1.
- R9: In the ninth clock of a received byte, the core drives the value of ack_val: 0 pulls SDA low (ACK) and 1 releases it (NACK).
- R10: When go is 0 at a byte boundary, the core produces a STOP (SDA rises while SCL is high) and then releases both lines.
- R11: One quarter phase lasts 8<<rate clock cycles, so the SCL period is 32<<rate cycles. Codes 0 to 7 give 32 up to 4096 cycles.
- R12: tx_flag_clr clears tx_flag and rx_flag_clr clears rx_flag, each to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Run bit: 1 starts/continues a transfer, 0 requests STOP |
| addr_sel | input | 1 | Chooses address register B (1) or A (0) |
| rate | input | 3 | SCL rate code |
| ack_val | input | 1 | Ninth-bit value driven after a received byte |
| addr_a_we | input | 1 | Write strobe for address register A |
| addr_b_we | input | 1 | Write strobe for address register B |
| addr_wd | input | 8 | Address write data |
| buf_we | input | 1 | Software write strobe for the data buffer |
| buf_wd | input | 8 | Buffer write data |
| tx_rdy_set | input | 1 | Sets tx_rdy |
| rx_rdy_clr | input | 1 | Clears rx_rdy |
| tx_flag_clr | input | 1 | Clears tx_flag |
| rx_flag_clr | input | 1 | Clears rx_flag |
| sda_in | input | 1 | Sensed SDA line level |
| addr_a_q | output | 8 | Address register A |
| addr_b_q | output | 8 | Address register B |
| buf_q | output | 8 | Data buffer |
| tx_rdy | output | 1 | Transmit-ready bit |
| rx_rdy | output | 1 | Receive-ready bit |
| tx_flag | output | 1 | Transmit interrupt flag |
| rx_flag | output | 1 | Receive interrupt flag |
| ack_seen | output | 1 | Acknowledge received after last sent byte |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume two things about the inputs. First, software has no way to set rx_rdy or to clear tx_rdy, so a store always finds the buffer free and a completed send always finds tx_rdy set. Second, sda_in is the wired-AND of the core and an attached device. The bench drives every strobe and level on the falling clock edge. Its device model changes SDA only after it has seen SCL low, and it releases SDA after a NACK so that the STOP can form. The rate code is changed only while the bus is idle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_XFER,
        S_HOLD,
        S_STOP
    } seq_st_t;

    // Events raised by the sequencer toward the register file
    typedef struct packed {
        logic              store;
        logic [BYTE_W-1:0] data;
        logic              load;
        logic              txdone;
        logic              ack_upd;
        logic              ack_bit;
    } core_ev_t;

    // Quarter-phase length in clock cycles for a rate code
    function automatic int unsigned quarter_len(input logic [2:0] code,
                                                input int unsigned base_div);
        return (base_div / 4) << code;
    endfunction

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick
    import i2cm_pkg::*;
#(
    parameter int BASE_DIV = 32,
    parameter int CW       = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] code,
    output logic       tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb lim = CW'(quarter_len(code, BASE_DIV) - 1);

    always_ff @(posedge clk) begin
        if (rst || !run)    cnt <= '0;
        else if (cnt >= lim) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt >= lim);

    // R11: the counter restarts after every quarter tick
    p_tick_restart_r11: assert property (@(posedge clk) disable iff (rst)
        (tick && run) |=> (cnt == '0));

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ADDR_A_RST = 8'hA0,
    parameter logic [BYTE_W-1:0] ADDR_B_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_a_we,
    input  logic              addr_b_we,
    input  logic [BYTE_W-1:0] addr_wd,
    input  logic              buf_we,
    input  logic [BYTE_W-1:0] buf_wd,
    input  logic              tx_rdy_set,
    input  logic              rx_rdy_clr,
    input  logic              tx_flag_clr,
    input  logic              rx_flag_clr,
    input  core_ev_t          ev,
    output logic [BYTE_W-1:0] addr_a,
    output logic [BYTE_W-1:0] addr_b,
    output logic [BYTE_W-1:0] buf_q,
    output logic              tx_rdy,
    output logic              rx_rdy,
    output logic              tx_flag,
    output logic              rx_flag,
    output logic              ack_seen
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_a   <= ADDR_A_RST;
            addr_b   <= ADDR_B_RST;
            buf_q    <= '0;
            tx_rdy   <= 1'b0;
            rx_rdy   <= 1'b0;
            tx_flag  <= 1'b0;
            rx_flag  <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            if (addr_a_we) addr_a <= addr_wd;
            if (addr_b_we) addr_b <= addr_wd;

            if (ev.store)    buf_q <= ev.data;
            else if (buf_we) buf_q <= buf_wd;

            if (tx_rdy_set)     tx_rdy <= 1'b1;
            else if (ev.txdone) tx_rdy <= 1'b0;

            if (ev.store)       rx_rdy <= 1'b1;
            else if (rx_rdy_clr) rx_rdy <= 1'b0;

            if (ev.load)         tx_flag <= 1'b1;
            else if (tx_flag_clr) tx_flag <= 1'b0;

            if (ev.store)        rx_flag <= 1'b1;
            else if (rx_flag_clr) rx_flag <= 1'b0;

            if (ev.ack_upd) ack_seen <= ev.ack_bit;
        end
    end

    // R4: a load into the shifter leaves tx_flag set
    p_load_flag_r4: assert property (@(posedge clk) disable iff (rst)
        ev.load |=> tx_flag);

    // R8: a stored byte is visible in the buffer with rx_rdy set
    p_store_visible_r8: assert property (@(posedge clk) disable iff (rst)
        ev.store |=> (rx_rdy && buf_q == $past(ev.data)));

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              go,
    input  logic              sel_b,
    input  logic [BYTE_W-1:0] addr_a,
    input  logic [BYTE_W-1:0] addr_b,
    input  logic [BYTE_W-1:0] buf_q,
    input  logic              tx_rdy,
    input  logic              rx_rdy,
    input  logic              ack_val,
    input  logic              sda_in,
    output logic              run,
    output logic              scl_oe,
    output logic              sda_oe,
    output core_ev_t          ev
);
    localparam int BW = $clog2(BYTE_W + 1);
    localparam logic [BW-1:0] ACK_SLOT = BW'(BYTE_W);

    seq_st_t           st;
    logic [1:0]        ph;
    logic [BW-1:0]     bitn;
    logic [BYTE_W-1:0] sh;
    logic              rd_mode, rw_q, is_addr, ack_q, samp;
    logic              wr_byte, byte_end;

    assign wr_byte  = !rd_mode || is_addr;
    assign byte_end = (st == S_XFER) && tick && (ph == 2'd3) && (bitn == ACK_SLOT);
    assign run      = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            ph      <= '0;
            bitn    <= '0;
            sh      <= '0;
            rd_mode <= 1'b0;
            rw_q    <= 1'b0;
            is_addr <= 1'b0;
            ack_q   <= 1'b1;
            samp    <= 1'b1;
        end else begin
            case (st)
                S_IDLE: if (go) begin
                    st <= S_START;
                    ph <= '0;
                end
                S_START: if (tick) begin
                    ph <= ph + 1'b1;
                    if (ph == 2'd3) begin
                        st      <= S_XFER;
                        bitn    <= '0;
                        sh      <= sel_b ? addr_b : addr_a;
                        rw_q    <= sel_b ? addr_b[0] : addr_a[0];
                        is_addr <= 1'b1;
                        rd_mode <= 1'b0;
                        ack_q   <= 1'b1;
                    end
                end
                S_XFER: if (tick) begin
                    ph <= ph + 1'b1;
                    if (ph == 2'd2) begin
                        if (bitn == ACK_SLOT)  samp <= sda_in;
                        else if (!wr_byte)     sh   <= {sh[BYTE_W-2:0], sda_in};
                    end
                    if (ph == 2'd3) begin
                        if (bitn == ACK_SLOT) begin
                            st <= S_HOLD;
                            if (is_addr) rd_mode <= rw_q;
                            is_addr <= 1'b0;
                        end else begin
                            bitn <= bitn + 1'b1;
                            if (wr_byte) sh <= {sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                S_HOLD: if (tick) begin
                    ph <= '0;
                    if (!go) begin
                        st <= S_STOP;
                    end else if (!rd_mode && tx_rdy) begin
                        st   <= S_XFER;
                        bitn <= '0;
                        sh   <= buf_q;
                    end else if (rd_mode && !rx_rdy) begin
                        st    <= S_XFER;
                        bitn  <= '0;
                        ack_q <= ack_val;
                    end
                end
                S_STOP: if (tick) begin
                    ph <= ph + 1'b1;
                    if (ph == 2'd3) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Bus drive from the phase state
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (st)
            S_START: begin
                scl_oe = (ph == 2'd3);
                sda_oe = (ph >= 2'd2);
            end
            S_XFER: begin
                scl_oe = (ph < 2'd2);
                if (bitn == ACK_SLOT) sda_oe = wr_byte ? 1'b0 : !ack_q;
                else                  sda_oe = wr_byte ? !sh[BYTE_W-1] : 1'b0;
            end
            S_HOLD: begin
                scl_oe = 1'b1;
                sda_oe = wr_byte ? 1'b0 : !ack_q;
            end
            S_STOP: begin
                scl_oe = (ph == 2'd0);
                sda_oe = (ph < 2'd2);
            end
            default: ;
        endcase
    end

    always_comb begin
        ev.load    = (st == S_HOLD) && tick && go && !rd_mode && tx_rdy;
        ev.txdone  = byte_end && !is_addr && !rd_mode;
        ev.ack_upd = byte_end && wr_byte;
        ev.ack_bit = samp;
        ev.store   = byte_end && !wr_byte;
        ev.data    = sh;
    end

    // R3: while SCL stays released in a byte, SDA does not move
    p_sda_steady_r3: assert property (@(posedge clk) disable iff (rst)
        (st == S_XFER && $past(st) == S_XFER && !scl_oe && !$past(scl_oe))
        |-> $stable(sda_oe));

    // R7: no read byte begins while the receive-ready bit is set
    p_rx_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (st == S_HOLD && rd_mode && rx_rdy && go) |=> (st == S_HOLD));

    // R8: a byte is only stored into a free buffer
    p_store_free_r8: assert property (@(posedge clk) disable iff (rst)
        ev.store |-> !rx_rdy);

    // R5: the core only finishes a send that software released
    p_txdone_ready_r5: assert property (@(posedge clk) disable iff (rst)
        ev.txdone |-> tx_rdy);

    // R2: a set run bit in idle always starts a transfer
    p_go_starts_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && go) |=> (st == S_START));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int BASE_DIV = 32,
    parameter int CW       = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       addr_sel,
    input  logic [2:0] rate,
    input  logic       ack_val,
    input  logic       addr_a_we,
    input  logic       addr_b_we,
    input  logic [7:0] addr_wd,
    input  logic       buf_we,
    input  logic [7:0] buf_wd,
    input  logic       tx_rdy_set,
    input  logic       rx_rdy_clr,
    input  logic       tx_flag_clr,
    input  logic       rx_flag_clr,
    input  logic       sda_in,
    output logic [7:0] addr_a_q,
    output logic [7:0] addr_b_q,
    output logic [7:0] buf_q,
    output logic       tx_rdy,
    output logic       rx_rdy,
    output logic       tx_flag,
    output logic       rx_flag,
    output logic       ack_seen,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic     tick, run;
    core_ev_t ev;

    i2cm_qtick #(.BASE_DIV(BASE_DIV), .CW(CW)) u_tick (
        .clk(clk), .rst(rst), .run(run), .code(rate), .tick(tick)
    );

    i2cm_regs u_regs (
        .clk(clk), .rst(rst),
        .addr_a_we(addr_a_we), .addr_b_we(addr_b_we), .addr_wd(addr_wd),
        .buf_we(buf_we), .buf_wd(buf_wd),
        .tx_rdy_set(tx_rdy_set), .rx_rdy_clr(rx_rdy_clr),
        .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
        .ev(ev),
        .addr_a(addr_a_q), .addr_b(addr_b_q), .buf_q(buf_q),
        .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
        .tx_flag(tx_flag), .rx_flag(rx_flag), .ack_seen(ack_seen)
    );

    i2cm_seq u_seq (
        .clk(clk), .rst(rst), .tick(tick), .go(go), .sel_b(addr_sel),
        .addr_a(addr_a_q), .addr_b(addr_b_q), .buf_q(buf_q),
        .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .ack_val(ack_val), .sda_in(sda_in),
        .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe), .ev(ev)
    );

    // R10: once idle with the run bit low, both lines stay released
    p_idle_release_r10: assert property (@(posedge clk) disable iff (rst)
        (!run && !go) |=> (!scl_oe && !sda_oe));

endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go = 1'b0, addr_sel = 1'b0, ack_val = 1'b0;
    logic [2:0] rate = 3'd0;
    logic       addr_a_we = 1'b0, addr_b_we = 1'b0, buf_we = 1'b0;
    logic [7:0] addr_wd = 8'h00, buf_wd = 8'h00;
    logic       tx_rdy_set = 1'b0, rx_rdy_clr = 1'b0, tx_flag_clr = 1'b0, rx_flag_clr = 1'b0;
    logic [7:0] addr_a_q, addr_b_q, buf_q;
    logic       tx_rdy, rx_rdy, tx_flag, rx_flag, ack_seen, scl_oe, sda_oe;

    logic s_low = 1'b0;
    wire  scl_line = !scl_oe;
    wire  sda_line = !(sda_oe || s_low);

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    i2c_byte_master u0 (
        .clk(clk), .rst(rst), .go(go), .addr_sel(addr_sel), .rate(rate),
        .ack_val(ack_val), .addr_a_we(addr_a_we), .addr_b_we(addr_b_we),
        .addr_wd(addr_wd), .buf_we(buf_we), .buf_wd(buf_wd),
        .tx_rdy_set(tx_rdy_set), .rx_rdy_clr(rx_rdy_clr),
        .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
        .sda_in(sda_line),
        .addr_a_q(addr_a_q), .addr_b_q(addr_b_q), .buf_q(buf_q),
        .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .tx_flag(tx_flag), .rx_flag(rx_flag),
        .ack_seen(ack_seen), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // ---------------- bus device model ----------------
    logic       nak = 1'b0;
    logic [7:0] tx_pat [0:3];
    logic [7:0] rx_log [0:7];
    logic       mack   [0:7];
    int rx_n, mack_n, starts, stops, rises, txi, cnt, per, t1;
    int cyc = 0;
    logic       first, s_tx, scl_p, sda_p;
    logic [7:0] rsh;

    always @(negedge clk) begin
        logic scl_now, sda_now;
        cyc++;
        scl_now = scl_line;
        sda_now = sda_line;
        if (rst) begin
            rx_n = 0; mack_n = 0; starts = 0; stops = 0; rises = 0;
            txi = 0; cnt = 0; per = 0; t1 = 0;
            first = 1'b0; s_tx = 1'b0; s_low = 1'b0; rsh = 8'h00;
            scl_p = 1'b1; sda_p = 1'b1;
        end else begin
            if (scl_p && scl_now && sda_p && !sda_now) begin
                starts++; cnt = 0; first = 1'b1; s_tx = 1'b0; s_low = 1'b0;
            end else if (scl_p && scl_now && !sda_p && sda_now) begin
                stops++; s_tx = 1'b0; s_low = 1'b0;
            end else if (!scl_p && scl_now) begin
                rises++;
                if (cnt < 8) begin
                    rsh = {rsh[6:0], sda_now};
                    cnt++;
                    if (cnt == 1) t1 = cyc;
                    if (cnt == 2) per = cyc - t1;
                    if (cnt == 8 && !s_tx && rx_n < 8) begin
                        rx_log[rx_n] = rsh; rx_n++;
                    end
                end else if (cnt == 8) begin
                    cnt = 9;
                    if (s_tx) begin
                        if (mack_n < 8) begin mack[mack_n] = sda_now; mack_n++; end
                        if (sda_now) s_tx = 1'b0;
                        else txi = (txi + 1) % 4;
                    end
                end
            end else if (scl_p && !scl_now) begin
                if (cnt == 8) begin
                    s_low = s_tx ? 1'b0 : !nak;
                end else if (cnt == 9) begin
                    cnt = 0;
                    if (first) begin first = 1'b0; s_tx = rsh[0]; end
                    s_low = s_tx ? !tx_pat[txi][7] : 1'b0;
                end else if (s_tx && cnt > 0 && cnt < 8) begin
                    s_low = !tx_pat[txi][7-cnt];
                end
            end
            scl_p = scl_now;
            sda_p = sda_now;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; go = 1'b0; addr_sel = 1'b0; rate = 3'd0; ack_val = 1'b0; nak = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_addr(input logic b, input logic [7:0] v);
        addr_wd = v;
        if (b) addr_b_we = 1'b1; else addr_a_we = 1'b1;
        @(negedge clk);
        addr_a_we = 1'b0; addr_b_we = 1'b0;
    endtask

    task automatic strobe_buf(input logic [7:0] v);
        buf_wd = v; buf_we = 1'b1;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic set_tx_rdy();
        tx_rdy_set = 1'b1; @(negedge clk); tx_rdy_set = 1'b0;
    endtask

    task automatic stop_and_check(input int exp_stops);
        go = 1'b0;
        for (int k = 0; k < 2000 && stops < exp_stops; k++) @(negedge clk);
        check("R10", "stop count", stops, exp_stops);
        wait_cyc(4);
        check("R10", "lines released", {30'd0, scl_oe, sda_oe}, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        do_reset();
        check("R1", "status bits", {27'd0, tx_rdy, rx_rdy, tx_flag, rx_flag, ack_seen}, 0);
        check("R1", "addr A", addr_a_q, 8'hA0);
        check("R1", "addr B", addr_b_q, 8'h00);
        check("R1", "lines", {30'd0, scl_oe, sda_oe}, 0);
    endtask

    task automatic t_write();
        int r0;
        do_reset();
        strobe_addr(1'b0, 8'hB4);
        strobe_buf(8'h3C);
        go = 1'b1;
        for (int k = 0; k < 2000 && rx_n < 1; k++) @(negedge clk);
        wait_cyc(300);
        check("R2", "start count", starts, 1);
        check("R2", "address byte A", rx_log[0], 8'hB4);
        check("R11", "SCL period code 0", per, 32);
        check("R6", "address ack", ack_seen, 0);
        r0 = rises;
        wait_cyc(200);
        check("R4", "bytes before tx_rdy", rx_n, 1);
        check("R4", "SCL held low", scl_line, 0);
        check("R4", "no clocks while waiting", rises, r0);
        check("R4", "tx_flag before load", tx_flag, 0);
        set_tx_rdy();
        for (int k = 0; k < 40 && !tx_flag; k++) @(negedge clk);
        check("R4", "tx_flag on load", tx_flag, 1);
        for (int k = 0; k < 2000 && rx_n < 2; k++) @(negedge clk);
        check("R5", "tx_rdy during byte", tx_rdy, 1);
        for (int k = 0; k < 200 && tx_rdy; k++) @(negedge clk);
        check("R5", "tx_rdy cleared", tx_rdy, 0);
        check("R4", "data byte", rx_log[1], 8'h3C);
        tx_flag_clr = 1'b1; @(negedge clk); tx_flag_clr = 1'b0;
        check("R12", "tx_flag cleared", tx_flag, 0);
        nak = 1'b1;
        strobe_buf(8'hC5);
        set_tx_rdy();
        for (int k = 0; k < 2000 && rx_n < 3; k++) @(negedge clk);
        for (int k = 0; k < 200 && tx_rdy; k++) @(negedge clk);
        check("R4", "second data byte", rx_log[2], 8'hC5);
        check("R6", "nack seen", ack_seen, 1);
        stop_and_check(1);
        check("R3", "single start", starts, 1);
    endtask

    task automatic t_read();
        int r0;
        do_reset();
        tx_pat[0] = 8'hA7; tx_pat[1] = 8'h5E; tx_pat[2] = 8'h00; tx_pat[3] = 8'h00;
        strobe_addr(1'b1, 8'h91);
        addr_sel = 1'b1;
        ack_val = 1'b0;
        go = 1'b1;
        for (int k = 0; k < 3000 && !rx_flag; k++) @(negedge clk);
        check("R2", "address byte B", rx_log[0], 8'h91);
        check("R8", "first byte stored", buf_q, 8'hA7);
        check("R8", "rx_rdy set", rx_rdy, 1);
        wait_cyc(400);
        r0 = rises;
        wait_cyc(300);
        check("R7", "no clocks while rx_rdy", rises, r0);
        check("R7", "SCL held low", scl_line, 0);
        check("R8", "buffer kept", buf_q, 8'hA7);
        check("R9", "ack count", mack_n, 1);
        check("R9", "ack driven", mack[0], 0);
        rx_flag_clr = 1'b1; @(negedge clk); rx_flag_clr = 1'b0;
        check("R12", "rx_flag cleared", rx_flag, 0);
        ack_val = 1'b1;
        rx_rdy_clr = 1'b1; @(negedge clk); rx_rdy_clr = 1'b0;
        for (int k = 0; k < 3000 && !rx_flag; k++) @(negedge clk);
        check("R8", "second byte stored", buf_q, 8'h5E);
        check("R9", "nack driven", mack[1], 1);
        stop_and_check(1);
        check("R3", "single start read", starts, 1);
    endtask

    task automatic t_rate(input logic [2:0] code, input int exp_per);
        do_reset();
        rate = code;
        go = 1'b1;
        for (int k = 0; k < 40000 && rx_n < 1; k++) @(negedge clk);
        check("R11", "SCL period", per, exp_per);
        check("R2", "default address A", rx_log[0], 8'hA0);
        stop_and_check(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_read();
        t_rate(3'd1, 64);
        t_rate(3'd3, 256);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule